// File: doc/BRIEF.md
# Reconfigurable Horner Polynomial Pipeline

This block evaluates a polynomial for each sample x that arrives on its input. It uses Horner's method on a chain of five registered multiply-and-add stages. The partial result starts from a leading coefficient. Each active stage k replaces the partial result p with p·x + c_k, where c_k is that stage's own coefficient. The last stage adds the constant term.

A two-bit degree code picks which stages do arithmetic. A stage that is switched off passes the partial result through unchanged. In this way one chain of five stages produces a degree-5, degree-4 or degree-3 polynomial. The code in force when a sample enters is carried down the chain with that sample. A reconfiguration therefore never corrupts results that are already in flight.

An optional aggregator can replace each result with the running sum of all results since the last clear. The coefficients, the degree code and the aggregation enable are loaded through a plain register-write port.

Top module: `horner_pipe`

## Requirements
- R1: While rst_n is low and after it is released, out_valid is 0. All six coefficients, the degree code and the aggregation enable reset to 0, so the first sample after reset gives out_y = 0.
- R2: A write with wr_en=1 stores wr_data as follows. Address 0 is the leading coefficient L. Addresses 1 to 5 are the stage coefficients c0 to c4. Address 6 takes bits [1:0] as the degree code and bit 2 as the aggregation enable. Address 7 changes nothing.
- R3: Starting from p = L, each active stage k (0 to 4, in order) computes p·x + c_k in 32-bit two's complement with wrap-around. Degree code 3 activates all five stages and gives L·x^5 + c0·x^4 + c1·x^3 + c2·x^2 + c3·x + c4.
- R4: Degree code 1 bypasses stage 1, which gives L·x^4 + c0·x^3 + c2·x^2 + c3·x + c4.
- R5: Degree code 2 bypasses stages 2 and 3, which gives L·x^3 + c0·x^2 + c1·x + c4.
- R6: Degree code 0 is illegal and behaves exactly like code 3.
- R7: A sample with in_valid=1 at a rising edge appears with out_valid=1 exactly five rising edges later, whatever the degree. A new sample is accepted every cycle.
- R8: Each sample uses the degree code held in the register at the edge where it enters. A code written while samples are in flight does not affect them.
- R9: With aggregation enabled, each result is output as the sum of every result since the last clear, the current one included, with 32-bit wrap.
- R10: acc_clr=1 zeroes the running sum. If it coincides with a valid result while aggregation is on, that result becomes the first term of the new sum.
- R11: out_y is 0 whenever out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Sample valid |
| in_x | input | 32 | Sample value x |
| acc_clr | input | 1 | Synchronous clear of the running sum |
| out_valid | output | 1 | Result valid |
| out_y | output | 32 | Polynomial result or running sum |

## Verification
The bench builds the block with its default 32-bit data width. At that width a sample of 0x10000 raised to the fourth and fifth power wraps, which exercises the two's-complement overflow behaviour. Negative coefficients and x = -1 exercise sign handling across all three degree codes and the illegal code. Back-to-back samples around a code change test that each sample keeps its degree in flight. A clear that lands on a valid result tests that the new sum starts with that result.

// File: rtl/horner_pipe.sv
module horner_pipe #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         in_valid,
  input  logic [W-1:0] in_x,
  input  logic         acc_clr,
  output logic         out_valid,
  output logic [W-1:0] out_y
);
  localparam int NS = 5;

  logic [W-1:0] coef [0:NS];
  logic [1:0]   cfg_code;
  logic         agg_en;

  logic [W-1:0] p_q  [0:NS-1];
  logic [W-1:0] x_q  [0:NS-2];
  logic [1:0]   cd_q [0:NS-2];
  logic [NS-1:0] v_q;
  logic [W-1:0] acc_q;

  function automatic logic stage_on(input int k, input logic [1:0] c);
    case (c)
      2'd1:    return k != 1;
      2'd2:    return (k != 2) && (k != 3);
      default: return 1'b1;
    endcase
  endfunction

  logic [W-1:0] nxt [0:NS-1];
  always_comb begin
    nxt[0] = stage_on(0, cfg_code) ? coef[0] * in_x + coef[1] : coef[0];
    for (int k = 1; k < NS; k++)
      nxt[k] = stage_on(k, cd_q[k-1]) ? p_q[k-1] * x_q[k-1] + coef[k+1] : p_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= NS; i++) coef[i] <= '0;
      cfg_code <= 2'd0;
      agg_en   <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr <= 3'd5) coef[wr_addr] <= wr_data;
      else if (wr_addr == 3'd6) {agg_en, cfg_code} <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int k = 0; k < NS; k++) p_q[k] <= '0;
      for (int k = 0; k < NS-1; k++) begin
        x_q[k]  <= '0;
        cd_q[k] <= 2'd0;
      end
    end else begin
      v_q <= {v_q[NS-2:0], in_valid};
      for (int k = 0; k < NS; k++) p_q[k] <= nxt[k];
      x_q[0]  <= in_x;
      cd_q[0] <= cfg_code;
      for (int k = 1; k < NS-1; k++) begin
        x_q[k]  <= x_q[k-1];
        cd_q[k] <= cd_q[k-1];
      end
    end
  end

  wire [W-1:0] base = acc_clr ? '0 : acc_q;
  wire [W-1:0] sum  = base + p_q[NS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= (v_q[NS-1] && agg_en) ? sum : base;
  end

  assign out_valid = v_q[NS-1];
  assign out_y = !v_q[NS-1] ? '0 : (agg_en ? sum : p_q[NS-1]);
endmodule

// File: rtl/horner_pipe_chk.sv
module horner_pipe_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic         in_valid,
  input logic         acc_clr,
  input logic         out_valid,
  input logic [W-1:0] out_y,
  input logic [1:0]   cfg_code,
  input logic         agg_en,
  input logic [W-1:0] acc_q
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd6) |=> ({agg_en, cfg_code} == $past(wr_data[2:0])));

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 5));

  // R10
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr && !out_valid) |=> (acc_q == '0));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_y == '0));
endmodule

bind horner_pipe horner_pipe_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .in_valid(in_valid), .acc_clr(acc_clr), .out_valid(out_valid), .out_y(out_y),
  .cfg_code(cfg_code), .agg_en(agg_en), .acc_q(acc_q)
);

// File: tb/sim_horner_pipe.sv
module sim_horner_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [33:0] VECS [0:NV-1] = '{
    {2'd3, 32'd2}, {2'd3, 32'hFFFFFFFF}, {2'd3, 32'h00010000}, {2'd1, 32'd3},
    {2'd1, 32'd0}, {2'd2, 32'd5}, {2'd2, 32'hFFFFFFFE}, {2'd0, 32'd2}
  };

  logic clk = 0, rst_n = 0, wr_en = 0, in_valid = 0, acc_clr = 0;
  logic [2:0] wr_addr = 0;
  logic [31:0] wr_data = 0, in_x = 0;
  logic out_valid;
  logic [31:0] out_y;
  logic [31:0] cf [0:5];
  int n_run = 0, n_fail = 0;
  logic [31:0] pa, pb, pc, acc;

  always #(CLK_PERIOD/2) clk = ~clk;

  horner_pipe u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .in_valid(in_valid), .in_x(in_x), .acc_clr(acc_clr),
    .out_valid(out_valid), .out_y(out_y));

  function automatic logic [31:0] model(input logic [1:0] c, input logic [31:0] x);
    logic [31:0] p = cf[0];
    for (int k = 0; k < 5; k++) begin
      logic on = (c == 2'd1) ? (k != 1) : (c == 2'd2) ? (k != 2 && k != 3) : 1'b1;
      if (on) p = p * x + cf[k+1];
    end
    return p;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (a <= 3'd5) cf[a] = d;
  endtask

  task automatic push_wait(input logic [31:0] x);
    @(negedge clk); in_valid = 1; in_x = x;
    @(negedge clk); in_valid = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) cf[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R11 idle out_y", out_y, 32'd0);
    push_wait(32'd5);
    check("R7 valid after five edges", {31'd0, out_valid}, 32'd1);
    check("R1 zero coefficients", out_y, 32'd0);
    @(negedge clk);
    check("R11 out_y after result", out_y, 32'd0);

    wr(3'd0, 32'd3); wr(3'd1, 32'hFFFFFFFE); wr(3'd2, 32'd5);
    wr(3'd3, 32'd7); wr(3'd4, 32'hFFFFFFFC); wr(3'd5, 32'd11);

    for (int i = 0; i < NV; i++) begin
      wr(3'd6, {30'd0, VECS[i][33:32]});
      push_wait(VECS[i][31:0]);
      case (VECS[i][33:32])
        2'd3: check("R3 degree five", out_y, model(2'd3, VECS[i][31:0]));
        2'd1: check("R4 degree four", out_y, model(2'd1, VECS[i][31:0]));
        2'd2: check("R5 degree three", out_y, model(2'd2, VECS[i][31:0]));
        default: check("R6 illegal code as degree five", out_y, model(2'd3, VECS[i][31:0]));
      endcase
    end

    wr(3'd7, 32'hDEADBEEF);
    wr(3'd6, 32'd3);
    push_wait(32'd2);
    check("R2 address 7 ignored", out_y, model(2'd3, 32'd2));

    @(negedge clk); in_valid = 1; in_x = 32'd2;
    @(negedge clk); in_x = 32'd3; wr_en = 1; wr_addr = 3'd6; wr_data = 32'd2;
    @(negedge clk); in_x = 32'd4; wr_en = 0;
    @(negedge clk); in_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 back-to-back first", out_y, model(2'd3, 32'd2));
    @(negedge clk);
    check("R8 in-flight keeps code", out_y, model(2'd3, 32'd3));
    @(negedge clk);
    check("R8 next sample new code", out_y, model(2'd2, 32'd4));

    wr(3'd6, 32'd7);
    @(negedge clk); acc_clr = 1;
    @(negedge clk); acc_clr = 0;
    pa = model(2'd3, 32'd1); pb = model(2'd3, 32'd2); pc = model(2'd3, 32'hFFFFFFFF);
    push_wait(32'd1);
    check("R9 first sum", out_y, pa);
    push_wait(32'd2);
    acc = pa + pb;
    check("R9 running sum", out_y, acc);
    push_wait(32'hFFFFFFFF);
    acc_clr = 1; #1;
    check("R10 clear with result", out_y, pc);
    @(negedge clk); acc_clr = 0;
    push_wait(32'd1);
    check("R10 sum restarts", out_y, pc + pa);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule